// File: doc/BRIEF.md
# Three-Channel Chainable Timer

This block holds three identical up-counting timer channels that share one prescaler, one clock-routing layer and one register write/read port. Each channel advances on a count tick taken from one of five divided versions of the master clock or from one of three external count lines. A block-level routing register decides, line by line, whether an external count line comes from a pin or from the waveform output A of one of the other two channels. With that routing, one channel can clock another, so two or three channels form a longer counter or a cascaded divider.

Each channel compares its count against its own compare register. A match resets the count and toggles waveform output A. Wrapping from all ones to zero toggles waveform output B. Both events set sticky status bits that can raise the channel's interrupt. A single write to the block sync address clears and starts all three channels on the same clock edge.

Software programs the block through a single-cycle write strobe. It reads registers through a combinational read port, and a read strobe clears status.

Top module: `tmr3_block`

## Requirements
- R1: After reset every counter reads 0, every channel is stopped, mode registers and the routing register read 0, compare registers read 0xFFFF, and all waveform and interrupt outputs are low.
- R2: Clock-select values 0,1,2,3,4 (mode bits [2:0]) give one count per 2, 8, 32, 128 and 1024 master-clock cycles respectively.
- R3: Clock-select values 5,6,7 count rising edges of external lines 0,1,2. Each line is synchronised through three flip-flops, so a count appears no later than four cycles after the rising edge.
- R4: The 2-bit routing field of external line j sits at bits [2j+1:2j] of the routing register (address 1). Value 0 selects pin j. Value 1 selects the output A of the lower-numbered of the other two channels, value 2 that of the higher-numbered one, and value 3 holds the line low.
- R5: A write to address 0 sets all three counters to 0 and starts all three channels on the same edge.
- R6: A control write (offset 0) with bit 0 set clears and starts the channel. With only bit 1 set it stops the channel, which then holds its count. Start wins if both bits are set.
- R7: With compare enable (mode bit 3) set, a tick while the count equals the compare register (offset 2) loads 0 into the count, toggles output A and sets status bit 0. With compare enable clear, the count never resets on a match.
- R8: A tick at count 0xFFFF wraps the count to 0, toggles output B and sets status bit 1.
- R9: The channel interrupt is high while status bit 0 is set with mode bit 4 set, or status bit 1 is set with mode bit 5 set. A read strobe on the status offset (3) clears both bits, and a new event in the same cycle wins.
- R10: Channel i sits at addresses 4(i+1) to 4(i+1)+3. The count reads at offset 0, the mode at 1, the compare value at 2 and the status at 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe; clears status when it hits a status offset |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 16 | Combinational read data |
| tclk_i | input | 3 | External count pins, one per external line |
| tioa_o | output | 3 | Waveform output A per channel (toggles on compare match) |
| tiob_o | output | 3 | Waveform output B per channel (toggles on wrap) |
| irq_o | output | 3 | Interrupt per channel |

## Verification
A register write takes effect on the edge that ends its strobe, so the bench reads back and samples outputs at the next falling edge. Divided-clock counts drift in phase with the prescaler. For that reason the bench measures them as the difference of two reads taken a whole multiple of the divide ratio apart, and that difference is exact whatever the phase. External edges take up to four cycles to reach the count, so the bench waits five cycles after the last pulse before the second read. For chained channels it uses a window that is a multiple of the output A period. Status and interrupt change on the same edge as the event. The bench checks interrupt clearing only after stopping the channel, so no new event can land on the clearing edge.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int NCH    = 3;
  localparam int NTAP   = 5;
  localparam int NXC    = 3;
  localparam int SEL_W  = 3;
  localparam int MODE_W = 6;
  localparam int AW     = 4;
  localparam int XS_W   = 2;

  localparam logic [AW-1:0] A_SYNC  = 4'h0;
  localparam logic [AW-1:0] A_BMODE = 4'h1;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_MODE = 2'd1;
  localparam logic [1:0] OFS_RC   = 2'd2;
  localparam logic [1:0] OFS_STAT = 2'd3;

  localparam int C_START  = 0;
  localparam int C_STOP   = 1;
  localparam int M_CMP_EN = 3;
  localparam int M_CMP_IE = 4;
  localparam int M_OVF_IE = 5;
  localparam int S_CMP    = 0;
  localparam int S_OVF    = 1;

  typedef enum logic [XS_W-1:0] {
    XS_PIN    = 2'd0,
    XS_SIB_LO = 2'd1,
    XS_SIB_HI = 2'd2,
    XS_OFF    = 2'd3
  } xc_src_e;

  // divide ratios 2,8,32,128,1024 as shift amounts
  function automatic int tap_shift(int k);
    return (k < NTAP - 1) ? 2 * k + 1 : 10;
  endfunction

  function automatic int sib_lo(int j);
    return (j == 0) ? 1 : 0;
  endfunction

  function automatic int sib_hi(int j);
    return (j == NCH - 1) ? NCH - 2 : NCH - 1;
  endfunction
endpackage

// File: rtl/tmr3_prescaler.sv
module tmr3_prescaler
  import tmr3_pkg::*;
#(
  parameter int N_TAPS = NTAP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [N_TAPS-1:0] tap_o
);
  localparam int PRE_W = tap_shift(N_TAPS - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    localparam int SH = tap_shift(k);
    assign tap_o[k] = &pre_q[SH-1:0];
  end
endmodule

// File: rtl/tmr3_edge_sync.sv
module tmr3_edge_sync #(
  parameter int STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], lvl_i};
  end

  assign rise_o = sh_q[STAGES-2] & ~sh_q[STAGES-1];
endmodule

// File: rtl/tmr3_channel.sv
module tmr3_channel
  import tmr3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NTAP-1:0]   tap_i,
  input  logic [NXC-1:0]    xc_i,
  input  logic              sync_i,
  input  logic              ctrl_we_i,
  input  logic              mode_we_i,
  input  logic              rc_we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic              stat_rd_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [CNT_W-1:0]  rc_o,
  output logic [1:0]        stat_o,
  output logic              run_o,
  output logic              tick_o,
  output logic              tioa_o,
  output logic              tiob_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]     cnt_q, rc_q;
  logic [MODE_W-1:0]    mode_q;
  logic [1:0]           stat_q;
  logic                 run_q, tioa_q, tiob_q;
  logic [NTAP+NXC-1:0]  src;
  logic                 start, ctl_hit, adv, hit_rc, hit_max;

  assign src     = {xc_i, tap_i};
  assign tick_o  = src[mode_q[SEL_W-1:0]];
  assign start   = sync_i | (ctrl_we_i & wdata_i[C_START]);
  assign ctl_hit = start | (ctrl_we_i & wdata_i[C_STOP]);
  assign adv     = run_q & tick_o & ~ctl_hit;
  assign hit_rc  = mode_q[M_CMP_EN] & (cnt_q == rc_q);
  assign hit_max = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (ctrl_we_i && wdata_i[C_STOP]) begin
      run_q <= 1'b0;
    end else if (adv) begin
      cnt_q <= hit_rc ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tioa_q <= 1'b0;
      tiob_q <= 1'b0;
      stat_q <= '0;
      mode_q <= '0;
      rc_q   <= '1;
    end else begin
      if (adv && hit_rc)  tioa_q <= ~tioa_q;
      if (adv && hit_max) tiob_q <= ~tiob_q;
      // set beats clear
      stat_q <= (stat_rd_i ? 2'b00 : stat_q) | {adv & hit_max, adv & hit_rc};
      if (mode_we_i) mode_q <= wdata_i[MODE_W-1:0];
      if (rc_we_i)   rc_q   <= wdata_i;
    end
  end

  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign rc_o   = rc_q;
  assign stat_o = stat_q;
  assign run_o  = run_q;
  assign tioa_o = tioa_q;
  assign tiob_o = tiob_q;
  assign irq_o  = (stat_q[S_CMP] & mode_q[M_CMP_IE]) | (stat_q[S_OVF] & mode_q[M_OVF_IE]);
endmodule

// File: rtl/tmr3_block.sv
module tmr3_block
  import tmr3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic [NXC-1:0]   tclk_i,
  output logic [NCH-1:0]   tioa_o,
  output logic [NCH-1:0]   tiob_o,
  output logic [NCH-1:0]   irq_o
);
  localparam int BM_W = NXC * XS_W;

  logic [BM_W-1:0]                bmode_q;
  logic [NTAP-1:0]                tap_w;
  logic [NXC-1:0]                 xc_raw, xc_rise;
  logic [NCH-1:0]                 tioa_w, run_w, tick_w, cmp_en_w;
  logic [NCH-1:0][CNT_W-1:0]      cnt_w, rc_w;
  logic [NCH-1:0][MODE_W-1:0]     mode_w;
  logic [NCH-1:0][1:0]            stat_w;
  logic                           sync_w;

  assign sync_w = wr_en_i && (wr_addr_i == A_SYNC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  bmode_q <= '0;
    else if (wr_en_i && wr_addr_i == A_BMODE)     bmode_q <= wr_data_i[BM_W-1:0];
  end

  tmr3_prescaler #(.N_TAPS(NTAP)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tap_o  (tap_w)
  );

  for (genvar j = 0; j < NXC; j++) begin : g_xc
    always_comb begin
      unique case (xc_src_e'(bmode_q[XS_W*j +: XS_W]))
        XS_PIN:    xc_raw[j] = tclk_i[j];
        XS_SIB_LO: xc_raw[j] = tioa_w[sib_lo(j)];
        XS_SIB_HI: xc_raw[j] = tioa_w[sib_hi(j)];
        default:   xc_raw[j] = 1'b0;
      endcase
    end

    tmr3_edge_sync #(.STAGES(3)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (xc_raw[j]),
      .rise_o (xc_rise[j])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ch_wr, ch_rd;
    assign ch_wr = wr_en_i && (wr_addr_i[AW-1:2] == 2'(i + 1));
    assign ch_rd = rd_en_i && (rd_addr_i == {2'(i + 1), OFS_STAT});

    tmr3_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tap_i     (tap_w),
      .xc_i      (xc_rise),
      .sync_i    (sync_w),
      .ctrl_we_i (ch_wr && wr_addr_i[1:0] == OFS_CTRL),
      .mode_we_i (ch_wr && wr_addr_i[1:0] == OFS_MODE),
      .rc_we_i   (ch_wr && wr_addr_i[1:0] == OFS_RC),
      .wdata_i   (wr_data_i),
      .stat_rd_i (ch_rd),
      .cnt_o     (cnt_w[i]),
      .mode_o    (mode_w[i]),
      .rc_o      (rc_w[i]),
      .stat_o    (stat_w[i]),
      .run_o     (run_w[i]),
      .tick_o    (tick_w[i]),
      .tioa_o    (tioa_w[i]),
      .tiob_o    (tiob_o[i]),
      .irq_o     (irq_o[i])
    );
    assign cmp_en_w[i] = mode_w[i][M_CMP_EN];
  end

  assign tioa_o = tioa_w;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_BMODE) rd_data_o = CNT_W'(bmode_q);
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr_i[AW-1:2] == 2'(i + 1)) begin
        unique case (rd_addr_i[1:0])
          OFS_CTRL: rd_data_o = cnt_w[i];
          OFS_MODE: rd_data_o = CNT_W'(mode_w[i]);
          OFS_RC:   rd_data_o = rc_w[i];
          default:  rd_data_o = CNT_W'(stat_w[i]);
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr3_block_chk.sv
module tmr3_block_chk
  import tmr3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic [AW-1:0]             wr_addr_i,
  input logic [NCH-1:0]            irq_o,
  input logic [NCH-1:0]            tioa_o,
  input logic [NCH-1:0][CNT_W-1:0] cnt_w,
  input logic [NCH-1:0][CNT_W-1:0] rc_w,
  input logic [NCH-1:0]            run_w,
  input logic [NCH-1:0]            tick_w,
  input logic [NCH-1:0]            cmp_en_w
);
  a_r5_sync_starts_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_SYNC) |=> (cnt_w == '0 && run_w == '1));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    logic ctl_wr;
    assign ctl_wr = wr_en_i && (wr_addr_i == A_SYNC || wr_addr_i == {2'(i + 1), OFS_CTRL});

    a_r6_stopped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_w[i] && !ctl_wr) |=> $stable(cnt_w[i]));

    a_r7_match_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[i] && tick_w[i] && !ctl_wr && cmp_en_w[i] && cnt_w[i] == rc_w[i])
      |=> (cnt_w[i] == '0 && tioa_o[i] != $past(tioa_o[i])));

    a_r2_tick_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[i] && tick_w[i] && !ctl_wr && !(cmp_en_w[i] && cnt_w[i] == rc_w[i]))
      |=> cnt_w[i] == CNT_W'($past(cnt_w[i]) + 1'b1));

    a_r9_irq_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o[i]) |-> $past((run_w[i] && tick_w[i]) || wr_en_i));
  end
endmodule

bind tmr3_block tmr3_block_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_tmr3_block.sv
module tb_tmr3_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [2:0]  tclk = '0;
  logic [2:0]  tioa, tiob, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr3_block dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tclk_i(tclk), .tioa_o(tioa), .tiob_o(tiob), .irq_o(irq)
  );

  // stimulus/expectation table: clock select, window in cycles, expected count delta (R2)
  localparam int NV = 5;
  localparam logic [2:0] V_SEL [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4};
  localparam int         V_WIN [NV] = '{20, 40, 96, 256, 2048};
  localparam int         V_EXP [NV] = '{10, 5, 3, 2, 2};

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    rd_addr = a; #1; d = int'(rd_data);
  endtask

  task automatic rdc(input logic [3:0] a, output int d);
    rd_en = 1'b1; rd_addr = a; #1; d = int'(rd_data);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulses(input int j, input int n);
    for (int p = 0; p < n; p++) begin
      tclk[j] = 1'b1; repeat (3) @(negedge clk);
      tclk[j] = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  function automatic logic [3:0] ca(input int ch, input int ofs);
    return 4'((ch + 1) * 4 + ofs);
  endfunction

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    int a, b, c, mx, n;
    int cv [3];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      rd(ca(i, 0), a); check("R1 count", a, 0);
      rd(ca(i, 2), a); check("R1 compare", a, 16'hFFFF);
    end
    rd(4'h1, a); check("R1 routing", a, 0);
    check("R1 outputs", int'({irq, tioa, tiob}), 0);
    rd(ca(0, 0), a); repeat (8) @(negedge clk); rd(ca(0, 0), b);
    check("R1 stopped", b, a);

    // R2 tap table, channel 0 free running
    wr(ca(0, 0), 16'h0001);
    for (int v = 0; v < NV; v++) begin
      wr(ca(0, 1), 16'(V_SEL[v]));
      rd(ca(0, 0), a);
      repeat (V_WIN[v]) @(negedge clk);
      rd(ca(0, 0), b);
      check("R2 tap delta", (b - a) & 16'hFFFF, V_EXP[v]);
    end
    rd(ca(0, 1), a); check("R10 mode readback", a, 4);

    // R5 block sync
    for (int i = 0; i < 3; i++) wr(ca(i, 1), 16'h0000);
    wr(4'h0, 16'h0001);
    for (int i = 0; i < 3; i++) begin rd(ca(i, 0), cv[i]); check("R5 cleared", cv[i], 0); end
    repeat (10) @(negedge clk);
    for (int i = 0; i < 3; i++) begin rd(ca(i, 0), cv[i]); check("R5 aligned", cv[i], 5); end

    // R6 stop and restart
    wr(ca(0, 0), 16'h0002);
    rd(ca(0, 0), a); repeat (20) @(negedge clk); rd(ca(0, 0), b);
    check("R6 stop holds", b, a);
    wr(ca(0, 0), 16'h0003);
    rd(ca(0, 0), a); check("R6 start wins", a, 0);

    // R7 compare reload, interrupt enable off then on
    wr(ca(0, 2), 16'd3);
    wr(ca(0, 1), 16'h0008);
    wr(ca(0, 0), 16'h0001);
    mx = 0;
    for (int t = 0; t < 40; t++) begin
      rd(ca(0, 0), a); if (a > mx) mx = a; @(negedge clk);
    end
    check("R7 count peak", mx, 3);
    a = int'(tioa[0]); repeat (8) @(negedge clk); b = int'(tioa[0]);
    check("R7 tioa toggles", b, 1 - a);
    check("R9 masked irq", int'(irq[0]), 0);
    rdc(ca(0, 3), a); check("R7 status", a & 1, 1);
    wr(ca(0, 1), 16'h0018);
    repeat (10) @(negedge clk);
    check("R9 irq raised", int'(irq[0]), 1);
    wr(ca(0, 0), 16'h0002);
    rdc(ca(0, 3), a);
    check("R9 irq cleared", int'(irq[0]), 0);

    // R3 external pin on line 0, R4 line held low
    wr(4'h1, 16'h0000);
    wr(ca(1, 1), 16'd5);
    wr(ca(1, 0), 16'h0001);
    rd(ca(1, 0), a); pulses(0, 7); repeat (5) @(negedge clk); rd(ca(1, 0), b);
    check("R3 pin edges", (b - a) & 16'hFFFF, 7);
    wr(4'h1, 16'h0003);
    rd(ca(1, 0), a); pulses(0, 5); repeat (5) @(negedge clk); rd(ca(1, 0), b);
    check("R4 line off", (b - a) & 16'hFFFF, 0);

    // R4 chaining: lines 1 and 2 from channel 0 output A (period 16 cycles)
    wr(4'h1, 16'h0014);
    wr(ca(1, 1), 16'd6);
    wr(ca(2, 1), 16'd7);
    wr(4'h0, 16'h0001);
    repeat (40) @(negedge clk);
    rd(ca(1, 0), a); rd(ca(2, 0), b);
    repeat (160) @(negedge clk);
    rd(ca(1, 0), c); check("R4 chain line1", (c - a) & 16'hFFFF, 10);
    rd(ca(2, 0), c); check("R4 chain line2", (c - b) & 16'hFFFF, 10);

    // R8 wrap on channel 1 at divide-by-2
    for (int i = 0; i < 3; i++) wr(ca(i, 0), 16'h0002);
    rdc(ca(1, 3), a);
    wr(ca(1, 1), 16'h0020);
    check("R8 tiob before", int'(tiob[1]), 0);
    wr(ca(1, 0), 16'h0001);
    n = 0;
    while (!irq[1] && n < 140000) begin @(negedge clk); n++; end
    check("R8 wrap time", int'(n >= 131068 && n <= 131076), 1);
    check("R8 tiob toggled", int'(tiob[1]), 1);
    rd(ca(1, 0), a); check("R8 count wrapped", int'(a <= 2), 1);
    rdc(ca(1, 3), a); check("R8 status", a, 2);
    check("R9 cleared after read", int'(irq[1]), 0);

    done = 1'b1;
    report();
  end
endmodule